// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block translates an effective address through a hashed page table that lives in external memory. The upper address bits select one of sixteen segment words. Each segment word carries a virtual segment identifier, two protection-key selectors, a no-execute flag and a direct-store flag. For a translatable segment the engine computes a 64-byte group address from the segment identifier, the page index and a table configuration word. It then scans the eight two-word entries of that group one memory word at a time.

If no entry in the primary group matches, the engine repeats the scan on the secondary group, whose hash is the inverted primary hash. When an entry matches, the engine checks that any further matching entries agree on their page number and attribute bits. It then decides the access rights from the protection key and the entry's two protection bits. Finally it sets the referenced and changed bits and writes the entry's second word back to memory if that word changed. The result is reported with a one-cycle done pulse, a status code, the physical page number and read/write permission flags.

The block is used by a processor's memory-management path after the direct block-translation check has missed. It is started by a single-cycle request and needs no other control.

Top module: `pgtbl_walker`

## Requirements
- R1: The segment word is selected by address bits 31:28. If its bit 31 is set, the request finishes with status 4 (direct-store) and makes no memory access.
- R2: An instruction fetch (req_fetch=1) from a segment whose bit 28 is set finishes with status 3 (no-execute) and makes no memory access. A data access to the same segment is translated normally.
- R3: The primary group address is table_cfg[31:16]<<16 OR (hash AND mask). Here hash = ((VSID XOR EA[27:12]) AND 0x7FFFF)<<6, mask = (table_cfg[8:0]<<16) OR 0xFFC0, and VSID is segment bits 23:0. Entry i lies at group+8*i, with word 0 at +0 and word 1 at +4. Each word is requested alone and the request is held until mem_ready. Word 1 is read only for entries whose word 0 matches.
- R4: An entry matches when word 0 bit 31 is 1, word 0 bit 6 equals the pass number (0 primary, 1 secondary), and word 0 bits 30:7 equal the VSID and bits 5:0 equal EA[27:22].
- R5: The secondary group is searched only when the primary group has no match. It uses hash' = (NOT hash) AND 0x01FFFFC0 and the same mask. No match in either group gives status 1 (not found).
- R6: The protection key is 1 when segment bit 29 is set and req_user=1, or when segment bit 30 is set and req_user=0. Otherwise it is 0.
- R7: With key 0, read is always allowed and write is allowed unless the protection bits (word 1 bits 1:0) equal 3. With key 1, value 2 allows read and write, values 1 and 3 allow read only, and value 0 allows nothing. A disallowed access gives status 2 and no write-back.
- R8: When several entries of a group match, their word-1 bits under mask 0xFFFFF07B must agree, and the first match is kept. A disagreement gives status 5 and no write-back. Differences only in bits 8 and 7 are accepted.
- R9: On an allowed access the referenced bit (word 1 bit 8) is set, and the changed bit (bit 7) is set on a write. Word 1 is written back to its own address only when its value changed.
- R10: On status 0 the page number output is word 1 bits 31:12 and perm_r is the read right. perm_w is the write right, but only when the changed bit is set after the update; otherwise it is 0.
- R11: done is high for exactly one cycle per accepted request, with status 0 for a successful translation. After reset, done and mem_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start pulse, taken when idle |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | 1 = store access |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_user | input | 1 | 1 = user privilege |
| seg_file | input | 512 | Sixteen 32-bit segment words, word n at bits 32n+31:32n |
| table_cfg | input | 32 | Table base (31:16) and size mask (8:0) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request; read data valid in the same cycle |
| mem_wr | output | 1 | 1 = write request |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 not found, 2 protection, 3 no-execute, 4 direct-store, 5 conflict |
| ppn | output | 20 | Physical page number |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |

## Verification
Table contents are laid out so that each pattern separates one decision. A hit at a middle slot of the primary group, together with a decoy whose VSID differs by one bit, checks the hash and tag logic and the number of reads. An entry that carries the correct tag but the secondary pass bit, placed in the primary group, shows that the pass bit is compared and forces the secondary walk. Repeated read, write and read accesses to one page separate the referenced-bit, changed-bit and no-write-back paths. Accesses to one entry under both privilege levels, plus protection values 0, 1 and 3, cover the key table. Paired duplicate entries that differ either in protection bits or only in referenced/changed bits separate a conflict from an accepted duplicate.

// File: rtl/pgtbl_pkg.sv
package pgtbl_pkg;
  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_MISS     = 3'd1;
  localparam logic [2:0] ST_PROT     = 3'd2;
  localparam logic [2:0] ST_NOEXEC   = 3'd3;
  localparam logic [2:0] ST_DIRECT   = 3'd4;
  localparam logic [2:0] ST_CONFLICT = 3'd5;

  localparam logic [31:0] CMP_MASK = 32'hFFFF_F07B;
  localparam logic [31:0] REF_BIT  = 32'h0000_0100;
  localparam logic [31:0] CHG_BIT  = 32'h0000_0080;

  function automatic logic pt_key(logic sup_sel, logic usr_sel, logic user);
    return (usr_sel & user) | (sup_sel & ~user);
  endfunction

  // returns {read, write}
  function automatic logic [1:0] pt_rights(logic key, logic [1:0] pp);
    if (!key) return {1'b1, (pp != 2'd3)};
    case (pp)
      2'd2:    return 2'b11;
      2'd0:    return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic [31:0] pt_group(logic [18:0] vsid_lo, logic [15:0] pg,
                                           logic [15:0] base, logic [8:0] msk,
                                           logic sec);
    logic [24:0] h;
    logic [24:0] m;
    h = {vsid_lo ^ {3'b000, pg}, 6'b0};
    if (sec) h = ~h & 25'h1FF_FFC0;
    m = {msk, 16'hFFC0};
    return {base, 16'h0000} | {7'h00, h & m};
  endfunction

  function automatic logic [30:0] pt_tag(logic [23:0] vsid, logic [5:0] api);
    return {vsid, 1'b0, api};
  endfunction

  function automatic logic pt_hit(logic [31:0] w0, logic [30:0] tag, logic pass);
    return w0[31] && (w0[6] == pass) && ({w0[30:7], 1'b0, w0[5:0]} == tag);
  endfunction
endpackage

// File: rtl/pgtbl_seg_sel.sv
module pgtbl_seg_sel import pgtbl_pkg::*; #(
  parameter int SEG_CNT = 16,
  localparam int SEG_BITS = $clog2(SEG_CNT)
) (
  input  logic [SEG_CNT*32-1:0] seg_file,
  input  logic [SEG_BITS-1:0]   seg_idx,
  input  logic                  user,
  output logic [23:0]           vsid,
  output logic                  key,
  output logic                  is_direct,
  output logic                  is_noexec
);
  logic [31:0] seg_arr [SEG_CNT];
  logic [31:0] sr;
  logic        unused_sr;

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_slot
    assign seg_arr[g] = seg_file[g*32 +: 32];
  end

  assign sr        = seg_arr[seg_idx];
  assign vsid      = sr[23:0];
  assign key       = pt_key(sr[30], sr[29], user);
  assign is_direct = sr[31];
  assign is_noexec = sr[28];
  assign unused_sr = ^sr[27:24];
endmodule

// File: rtl/pgtbl_addr_gen.sv
module pgtbl_addr_gen import pgtbl_pkg::*; #(
  parameter int GROUP_ENTRIES = 8,
  localparam int IDX_W = $clog2(GROUP_ENTRIES)
) (
  input  logic [18:0]      vsid_lo,
  input  logic [15:0]      pg,
  input  logic [15:0]      base,
  input  logic [8:0]       msk,
  input  logic             pass,
  input  logic [IDX_W-1:0] idx,
  input  logic             word,
  output logic [31:0]      addr
);
  logic [31:0] grp;
  assign grp  = pt_group(vsid_lo, pg, base, msk, pass);
  assign addr = grp | 32'({idx, word, 2'b00});
endmodule

// File: rtl/pgtbl_walker.sv
module pgtbl_walker import pgtbl_pkg::*; #(
  parameter int SEG_CNT       = 16,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_ea,
  input  logic                  req_write,
  input  logic                  req_fetch,
  input  logic                  req_user,
  input  logic [SEG_CNT*32-1:0] seg_file,
  input  logic [31:0]           table_cfg,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_wr,
  output logic [31:0]           mem_addr,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  output logic                  done,
  output logic [2:0]            status,
  output logic [19:0]           ppn,
  output logic                  perm_r,
  output logic                  perm_w
);
  localparam int SEG_BITS = $clog2(SEG_CNT);
  localparam int IDX_W    = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_WB, S_DONE} state_e;
  state_e state;

  logic [23:0]      vsid_q;
  logic [15:0]      pg_q, base_q;
  logic [8:0]       msk_q;
  logic             wr_q, key_q, pass_q, found_q;
  logic [IDX_W-1:0] idx_q, good_q;
  logic [31:0]      keep_q, wb_q;
  logic [2:0]       res_status;
  logic [19:0]      res_ppn;
  logic             res_r, res_w;

  logic [23:0] sel_vsid;
  logic        sel_key, sel_direct, sel_noexec;
  logic        unused_in;

  pgtbl_seg_sel #(.SEG_CNT(SEG_CNT)) u_seg (
    .seg_file(seg_file), .seg_idx(req_ea[31 -: SEG_BITS]), .user(req_user),
    .vsid(sel_vsid), .key(sel_key), .is_direct(sel_direct), .is_noexec(sel_noexec)
  );

  pgtbl_addr_gen #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_addr (
    .vsid_lo(vsid_q[18:0]), .pg(pg_q), .base(base_q), .msk(msk_q), .pass(pass_q),
    .idx(state == S_WB ? good_q : idx_q), .word(state != S_RD0), .addr(mem_addr)
  );

  assign unused_in = ^{req_ea[11:0], table_cfg[15:9]};

  // Named internal events
  logic        acc_fire, w0_hit, dup_bad, scan_last, step_done, found_fin, grant;
  logic [31:0] keep_fin, upd_word;
  logic [IDX_W-1:0] good_fin;
  logic [1:0]  rights;

  assign mem_valid = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
  assign mem_wr    = (state == S_WB);
  assign mem_wdata = wb_q;
  assign acc_fire  = mem_valid & mem_ready;
  assign w0_hit    = pt_hit(mem_rdata, pt_tag(vsid_q, pg_q[15:10]), pass_q);
  assign dup_bad   = found_q && (((keep_q ^ mem_rdata) & CMP_MASK) != 32'h0);
  assign scan_last = (idx_q == LAST_IDX);
  assign step_done = acc_fire && (((state == S_RD0) && !w0_hit) ||
                                  ((state == S_RD1) && !dup_bad));
  assign found_fin = found_q | (state == S_RD1);
  assign keep_fin  = ((state == S_RD1) && !found_q) ? mem_rdata : keep_q;
  assign good_fin  = found_q ? good_q : idx_q;
  assign rights    = pt_rights(key_q, keep_fin[1:0]);
  assign grant     = wr_q ? rights[0] : rights[1];
  assign upd_word  = keep_fin | REF_BIT | (wr_q ? CHG_BIT : 32'h0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      vsid_q <= '0; pg_q <= '0; base_q <= '0; msk_q <= '0;
      wr_q <= 1'b0; key_q <= 1'b0; pass_q <= 1'b0; found_q <= 1'b0;
      idx_q <= '0; good_q <= '0; keep_q <= '0; wb_q <= '0;
      res_status <= ST_OK; res_ppn <= '0; res_r <= 1'b0; res_w <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          vsid_q <= sel_vsid; pg_q <= req_ea[27:12];
          base_q <= table_cfg[31:16]; msk_q <= table_cfg[8:0];
          wr_q <= req_write; key_q <= sel_key;
          pass_q <= 1'b0; idx_q <= '0; found_q <= 1'b0;
          res_r <= 1'b0; res_w <= 1'b0; res_ppn <= '0;
          if (sel_direct) begin
            res_status <= ST_DIRECT; state <= S_DONE;
          end else if (req_fetch && sel_noexec) begin
            res_status <= ST_NOEXEC; state <= S_DONE;
          end else begin
            state <= S_RD0;
          end
        end
        S_RD0: if (acc_fire && w0_hit) state <= S_RD1;
        S_RD1: if (acc_fire) begin
          if (dup_bad) begin
            res_status <= ST_CONFLICT; state <= S_DONE;
          end else if (!found_q) begin
            found_q <= 1'b1; keep_q <= mem_rdata; good_q <= idx_q;
          end
        end
        S_WB: if (acc_fire) begin
          res_status <= ST_OK; state <= S_DONE;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (step_done) begin
        if (!scan_last) begin
          idx_q <= idx_q + 1'b1; state <= S_RD0;
        end else if (!found_fin) begin
          if (!pass_q) begin
            pass_q <= 1'b1; idx_q <= '0; state <= S_RD0;
          end else begin
            res_status <= ST_MISS; state <= S_DONE;
          end
        end else begin
          keep_q <= keep_fin; good_q <= good_fin; res_ppn <= keep_fin[31:12];
          if (!grant) begin
            res_status <= ST_PROT; state <= S_DONE;
          end else begin
            res_r <= rights[1];
            res_w <= rights[0] & upd_word[7];
            if (upd_word != keep_fin) begin
              wb_q <= upd_word; state <= S_WB;
            end else begin
              res_status <= ST_OK; state <= S_DONE;
            end
          end
        end
      end
    end
  end

  assign done   = (state == S_DONE);
  assign status = res_status;
  assign ppn    = res_ppn;
  assign perm_r = res_r;
  assign perm_w = res_w;
endmodule

// File: rtl/pgtbl_walker_chk.sv
module pgtbl_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [2:0]  status,
  input logic        perm_r,
  input logic        perm_w,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_wr,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_valid);

  // R3
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wr)));

  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R9
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_wr) |-> (mem_wdata[8] && mem_addr[2]));

  // R10
  perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && perm_w) |-> (perm_r && status == 3'd0));
endmodule

bind pgtbl_walker pgtbl_walker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .status(status),
  .perm_r(perm_r), .perm_w(perm_w), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/pgtbl_walker_tb_top.sv
`timescale 1ns/1ps
module pgtbl_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [16*32-1:0] seg_file = '0;
  logic [31:0] table_cfg = 32'h0010_0000;
  logic mem_valid, mem_wr, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic done, perm_r, perm_w;
  logic [2:0] status;
  logic [19:0] ppn;

  always #4 clk = ~clk;

  pgtbl_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .seg_file(seg_file), .table_cfg(table_cfg),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .status(status), .ppn(ppn), .perm_r(perm_r), .perm_w(perm_w)
  );

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0, done_seen = 0, mem_lat = 0, wcnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [24:0] exp_q [$];
  string tag_q [$];

  function automatic logic [31:0] mrd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // Group address written bit-field by bit-field from R3/R5
  function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [15:0] pg, input bit sec);
    logic [18:0] h;
    h = vsid[18:0] ^ {3'b000, pg};
    if (sec) h = ~h;
    return {table_cfg[31:16] | {7'h00, h[18:10] & table_cfg[8:0]}, h[9:0], 6'b0};
  endfunction

  function automatic logic [31:0] w0f(input logic [23:0] vsid, input logic [15:0] pg, input bit pass);
    return {1'b1, vsid, pass, pg[15:10]};
  endfunction

  task automatic put(input logic [31:0] g, input int i, input logic [31:0] w0, input logic [31:0] w1);
    mem[g + 32'(i*8)] = w0;
    mem[g + 32'(i*8) + 4] = w1;
  endtask

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // Memory responder
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_valid) begin
      if (wcnt >= mem_lat) begin
        mem_ready = 1'b1; wcnt = 0;
        if (mem_wr) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
        else begin mem_rdata = mrd(mem_addr); rd_cnt++; end
      end else wcnt++;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 32'(status), 32'hX);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(status == e[24:22], {t, " status"}, 32'(status), 32'(e[24:22]));
        if (e[24:22] == 3'd0)
          chk({perm_r, perm_w, ppn} == e[21:0], {t, " perm/ppn"},
              32'({perm_r, perm_w, ppn}), 32'(e[21:0]));
      end
      done_seen++;
    end
  end

  task automatic run(input logic [31:0] ea, input logic wr, input logic fe, input logic us,
                     input logic [2:0] st, input logic [19:0] pn, input logic r, input logic w,
                     input string tag);
    int start;
    exp_q.push_back({st, r, w, pn});
    tag_q.push_back(tag);
    start = done_seen;
    @(negedge clk);
    req_ea = ea; req_write = wr; req_fetch = fe; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (done_seen == start) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    int r0, w0c;
    seg_file[1*32 +: 32] = 32'h8000_0000;
    seg_file[2*32 +: 32] = 32'h1000_0222;
    seg_file[3*32 +: 32] = 32'h0012_3456;
    seg_file[5*32 +: 32] = 32'h2000_0777;
    seg_file[6*32 +: 32] = 32'h0000_0999;

    // Page 0xABCD in segment 3: hit at slot 3, decoy with VSID off by one at slot 1
    put(grp(24'h123456, 16'hABCD, 0), 3, w0f(24'h123456, 16'hABCD, 0), 32'hCAFE_1002);
    put(grp(24'h123456, 16'hABCD, 0), 1, w0f(24'h123457, 16'hABCD, 0), 32'h1111_1002);
    // Page 0x1234: secondary-tagged entry in primary group, real entry in secondary slot 7
    put(grp(24'h123456, 16'h1234, 0), 0, w0f(24'h123456, 16'h1234, 1), 32'h2222_2002);
    put(grp(24'h123456, 16'h1234, 1), 7, w0f(24'h123456, 16'h1234, 1), 32'h0BEE_F182);
    // Segment 5 pages with protection 0 and 1
    put(grp(24'h000777, 16'h0001, 0), 0, w0f(24'h000777, 16'h0001, 0), 32'h0011_1000);
    put(grp(24'h000777, 16'h0002, 0), 2, w0f(24'h000777, 16'h0002, 0), 32'h0022_2001);
    // Segment 3 page 3 with protection 3, changed bit already set
    put(grp(24'h123456, 16'h0003, 0), 4, w0f(24'h123456, 16'h0003, 0), 32'h0033_3083);
    // Segment 6: conflicting duplicates, then benign duplicates
    put(grp(24'h000999, 16'h0007, 0), 1, w0f(24'h000999, 16'h0007, 0), 32'h0044_4002);
    put(grp(24'h000999, 16'h0007, 0), 5, w0f(24'h000999, 16'h0007, 0), 32'h0044_4003);
    put(grp(24'h000999, 16'h0008, 0), 0, w0f(24'h000999, 16'h0008, 0), 32'h0055_5102);
    put(grp(24'h000999, 16'h0008, 0), 6, w0f(24'h000999, 16'h0008, 0), 32'h0055_5082);

    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_valid == 1'b0, "R11 reset state", 32'({done, mem_valid}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    r0 = rd_cnt;
    run(32'h1000_0000, 0, 0, 0, 3'd4, 20'h0, 0, 0, "R1 direct-store");
    chk(rd_cnt == r0, "R1 no memory reads", 32'(rd_cnt - r0), 32'h0);

    r0 = rd_cnt;
    run(32'h2000_0000, 0, 1, 0, 3'd3, 20'h0, 0, 0, "R2 no-execute fetch");
    chk(rd_cnt == r0, "R2 no memory reads", 32'(rd_cnt - r0), 32'h0);

    mem_lat = 2;
    r0 = rd_cnt;
    run(32'h2000_5000, 0, 0, 0, 3'd1, 20'h0, 0, 0, "R2 R5 data access, both groups empty");
    chk(rd_cnt - r0 == 16, "R5 both groups scanned", 32'(rd_cnt - r0), 32'd16);

    mem_lat = 0;
    r0 = rd_cnt; w0c = wr_cnt;
    run(32'h3ABC_D000, 0, 0, 0, 3'd0, 20'hCAFE1, 1, 0, "R3 R4 R10 primary hit read");
    chk(rd_cnt - r0 == 9, "R3 reads with word1 only on match", 32'(rd_cnt - r0), 32'd9);
    chk(wr_cnt - w0c == 1, "R9 one write-back", 32'(wr_cnt - w0c), 32'd1);
    chk(mrd(grp(24'h123456, 16'hABCD, 0) + 28) == 32'hCAFE_1102, "R9 referenced bit set",
        mrd(grp(24'h123456, 16'hABCD, 0) + 28), 32'hCAFE_1102);

    mem_lat = 1;
    run(32'h3ABC_D000, 1, 0, 0, 3'd0, 20'hCAFE1, 1, 1, "R9 R10 first write");
    chk(mrd(grp(24'h123456, 16'hABCD, 0) + 28) == 32'hCAFE_1182, "R9 changed bit set",
        mrd(grp(24'h123456, 16'hABCD, 0) + 28), 32'hCAFE_1182);

    w0c = wr_cnt;
    run(32'h3ABC_D000, 0, 0, 0, 3'd0, 20'hCAFE1, 1, 1, "R9 R10 read after write");
    chk(wr_cnt == w0c, "R9 no write-back when unchanged", 32'(wr_cnt - w0c), 32'h0);

    mem_lat = 0;
    w0c = wr_cnt;
    run(32'h3123_4000, 0, 0, 0, 3'd0, 20'h0BEEF, 1, 1, "R4 R5 secondary hit");
    chk(wr_cnt == w0c, "R5 secondary hit needs no write", 32'(wr_cnt - w0c), 32'h0);

    w0c = wr_cnt;
    run(32'h5000_1000, 0, 0, 1, 3'd2, 20'h0, 0, 0, "R6 R7 user key1 pp0 read");
    chk(wr_cnt == w0c, "R7 no write-back on denial", 32'(wr_cnt - w0c), 32'h0);
    run(32'h5000_1000, 0, 0, 0, 3'd0, 20'h00111, 1, 0, "R6 supervisor key0 read");

    run(32'h5000_2000, 1, 0, 1, 3'd2, 20'h0, 0, 0, "R7 key1 pp1 write");
    run(32'h5000_2000, 0, 0, 1, 3'd0, 20'h00222, 1, 0, "R7 key1 pp1 read");

    run(32'h3000_3000, 1, 0, 0, 3'd2, 20'h0, 0, 0, "R7 key0 pp3 write");
    run(32'h3000_3000, 0, 0, 0, 3'd0, 20'h00333, 1, 0, "R7 R10 key0 pp3 read");
    chk(mrd(grp(24'h123456, 16'h0003, 0) + 36) == 32'h0033_3183, "R9 pp3 referenced write-back",
        mrd(grp(24'h123456, 16'h0003, 0) + 36), 32'h0033_3183);

    w0c = wr_cnt;
    run(32'h6000_7000, 0, 0, 0, 3'd5, 20'h0, 0, 0, "R8 conflicting duplicates");
    chk(wr_cnt == w0c, "R8 no write-back on conflict", 32'(wr_cnt - w0c), 32'h0);

    w0c = wr_cnt;
    run(32'h6000_8000, 0, 0, 0, 3'd0, 20'h00555, 1, 0, "R8 duplicates differing in R/C only");
    chk(wr_cnt == w0c, "R8 first match kept, unchanged", 32'(wr_cnt - w0c), 32'h0);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R11 every request completed", 32'(exp_q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule